// File: doc/BRIEF.md
# Power and Sleep Domain Controller

This block is the control side of a power manager for a group of on-chip modules that are spread over a few power domains. Software reaches it through a small register bus. The bus has an address, write data, read data, and separate read and write strobes. Each module has a control register that holds the state software asks for, and a status register that holds the state in effect. A new control value does not take effect when it is written. It takes effect only when software issues a per-domain GO command. When the transition completes, every module in that domain copies its requested state into its status.

A domain can be powered off. If software issues GO on an off domain that has power-on requested, the controller flags external power as pending and holds the transition. Software must then confirm power-good before the transition can run. After power-good is accepted, the domain reads back as powered on. A fixed latency follows before the busy flag clears. Clock gating and the analog power switches sit outside this block.

Top module: `pwr_domain_ctrl`

## Requirements
- R1: After reset the following hold. Every module control and status register reads 0, with status bit 12 low. Busy and pending read 0. Domain 0 status bit 0 reads 1 and domain 1 status bit 0 reads 0. Domain 0 control reads 1 and domain 1 control reads 0.
- R2: Module control registers sit at 0xA00 + 4*m. Bits 4:0 hold the requested state and can be read back; all other bits read 0. Writing a control register leaves the module's status unchanged.
- R3: Module status registers sit at 0x800 + 4*m. Bits 4:0 hold the current state. Bit 12 reads 1 exactly when that state is 3 (enabled) or 1 (clocked reset).
- R4: Writing 1 to bit d of the command register at 0x120 starts a transition on domain d. Bit d of the busy register at 0x128 then reads 1 for exactly XFER_LAT cycles. The command register always reads 0.
- R5: When a transition on domain d completes, each module in domain d takes its control state into status. Modules of other domains keep their status. Module m belongs to domain (m*N_DOM)/N_MOD; with the defaults, modules 0-3 are in domain 0 and modules 4-7 are in domain 1.
- R6: Consider a GO on a domain whose status bit 0 (at 0x200 + 4*d) is 0 while its control bit 0 (at 0x300 + 4*d) is 1. That GO sets bit d of the pending register at 0x070. The domain then stays busy, with no status change, until bit 8 of its domain control register is written to 1.
- R7: When power-good is accepted, the domain's pending bit clears, its status bit 0 sets, and control bit 8 reads 0 again. Busy then stays high for XFER_LAT more cycles, so busy lasts XFER_LAT+1 cycles counted from the power-good write.
- R8: A GO for a domain that is already busy is ignored, and the transition in progress keeps its original end cycle.
- R9: A GO on an off domain whose control bit 0 is 0 runs without the handshake, and the domain stays off.
- R10: Reads of unmapped addresses, and any read with the read strobe low, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational, 0 while bus_rd is low |

## Verification
A full sweep of all 32 state codes runs through every module at once, each module with a different code. This separates the clock-active decode of each value and catches field cross-talk between modules. GO is issued to one domain at a time while the other domain holds pending values, which separates a correct module-to-domain map from a shared apply. Off-domain GO is tried both with and without a power-on request, and busy is timed with a cycle count, which separates the handshake path from the direct path and exposes a wrong latency. A second GO during busy shows whether the end cycle gets extended.

// File: rtl/pwr_ctrl_pkg.sv
package pwr_ctrl_pkg;

  localparam int unsigned STATE_W = 5;

  localparam logic [STATE_W-1:0] ST_CLKRST = 5'd1;
  localparam logic [STATE_W-1:0] ST_ENABLE = 5'd3;

  localparam int unsigned CLK_ON_BIT = 12;
  localparam int unsigned PG_BIT     = 8;

  localparam logic [11:0] OFS_PEND  = 12'h070;
  localparam logic [11:0] OFS_CMD   = 12'h120;
  localparam logic [11:0] OFS_BUSY  = 12'h128;
  localparam logic [11:0] OFS_DSTAT = 12'h200;
  localparam logic [11:0] OFS_DCTL  = 12'h300;
  localparam logic [11:0] OFS_MSTAT = 12'h800;
  localparam logic [11:0] OFS_MCTL  = 12'hA00;

  typedef enum logic [1:0] {
    DS_IDLE    = 2'd0,
    DS_WAIT_PG = 2'd1,
    DS_RUN     = 2'd2
  } dom_state_e;

  function automatic logic clk_active(input logic [STATE_W-1:0] st);
    return (st == ST_ENABLE) || (st == ST_CLKRST);
  endfunction

endpackage

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq
  import pwr_ctrl_pkg::*;
#(
  parameter int unsigned XFER_LAT = 4,
  parameter bit          RESET_ON = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  input  logic ctl_wr_i,
  input  logic req_wdata_i,
  input  logic pg_wdata_i,
  output logic busy_o,
  output logic pending_o,
  output logic pwr_on_o,
  output logic req_o,
  output logic pg_o,
  output logic apply_o
);

  localparam int unsigned CNT_W = (XFER_LAT < 2) ? 1 : $clog2(XFER_LAT);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(XFER_LAT - 1);

  dom_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic            pend_q, pend_d;
  logic            on_q, on_d;
  logic            req_q, req_d;
  logic            pg_q, pg_d;
  logic            take_pg;
  logic            apply_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    pend_d  = pend_q;
    on_d    = on_q;
    apply_d = 1'b0;
    take_pg = 1'b0;
    case (state_q)
      DS_IDLE: begin
        if (go_i) begin
          if (!on_q && req_q) begin
            state_d = DS_WAIT_PG;
            pend_d  = 1'b1;
          end else begin
            state_d = DS_RUN;
            cnt_d   = CNT_LOAD;
          end
        end
      end
      DS_WAIT_PG: begin
        if (pg_q) begin
          take_pg = 1'b1;
          pend_d  = 1'b0;
          on_d    = 1'b1;
          state_d = DS_RUN;
          cnt_d   = CNT_LOAD;
        end
      end
      DS_RUN: begin
        if (cnt_q == '0) begin
          state_d = DS_IDLE;
          apply_d = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = DS_IDLE;
    endcase

    req_d = ctl_wr_i ? req_wdata_i : req_q;
    if (take_pg)       pg_d = 1'b0;
    else if (ctl_wr_i) pg_d = pg_wdata_i;
    else               pg_d = pg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DS_IDLE;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      on_q    <= RESET_ON;
      req_q   <= RESET_ON;
      pg_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
      on_q    <= on_d;
      req_q   <= req_d;
      pg_q    <= pg_d;
    end
  end

  assign busy_o    = (state_q != DS_IDLE);
  assign pending_o = pend_q;
  assign pwr_on_o  = on_q;
  assign req_o     = req_q;
  assign pg_o      = pg_q;
  assign apply_o   = apply_d;

endmodule

// File: rtl/pwr_mod_slot.sv
module pwr_mod_slot
  import pwr_ctrl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_wr_i,
  input  logic [STATE_W-1:0] ctl_wdata_i,
  input  logic               apply_i,
  output logic [STATE_W-1:0] ctl_o,
  output logic [STATE_W-1:0] stat_o,
  output logic               clk_on_o
);

  logic [STATE_W-1:0] ctl_q, ctl_d;
  logic [STATE_W-1:0] stat_q, stat_d;

  always_comb begin
    ctl_d  = ctl_wr_i ? ctl_wdata_i : ctl_q;
    stat_d = apply_i ? ctl_q : stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      stat_q <= '0;
    end else begin
      ctl_q  <= ctl_d;
      stat_q <= stat_d;
    end
  end

  assign ctl_o    = ctl_q;
  assign stat_o   = stat_q;
  assign clk_on_o = clk_active(stat_q);

endmodule

// File: rtl/pwr_domain_ctrl.sv
module pwr_domain_ctrl
  import pwr_ctrl_pkg::*;
#(
  parameter int unsigned N_DOM    = 2,
  parameter int unsigned N_MOD    = 8,
  parameter int unsigned XFER_LAT = 4,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata
);

  logic [N_DOM-1:0] go_v, dctl_wr_v;
  logic [N_DOM-1:0] busy_v, pend_v, pwr_on_v, req_v, pg_v, apply_v;
  logic [N_MOD-1:0] mctl_wr_v, clk_on_v;
  logic [N_MOD*STATE_W-1:0] ctl_flat, stat_flat;

  assign go_v = (bus_wr && bus_addr == ADDR_W'(OFS_CMD)) ? bus_wdata[N_DOM-1:0] : '0;

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    assign dctl_wr_v[d] = bus_wr && (bus_addr == ADDR_W'(OFS_DCTL + 12'(4 * d)));

    pwr_dom_seq #(
      .XFER_LAT (XFER_LAT),
      .RESET_ON (d == 0)
    ) seq_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .go_i        (go_v[d]),
      .ctl_wr_i    (dctl_wr_v[d]),
      .req_wdata_i (bus_wdata[0]),
      .pg_wdata_i  (bus_wdata[PG_BIT]),
      .busy_o      (busy_v[d]),
      .pending_o   (pend_v[d]),
      .pwr_on_o    (pwr_on_v[d]),
      .req_o       (req_v[d]),
      .pg_o        (pg_v[d]),
      .apply_o     (apply_v[d])
    );
  end

  for (genvar m = 0; m < N_MOD; m++) begin : g_mod
    localparam int unsigned MOD_DOM = (m * N_DOM) / N_MOD;
    assign mctl_wr_v[m] = bus_wr && (bus_addr == ADDR_W'(OFS_MCTL + 12'(4 * m)));

    pwr_mod_slot slot_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctl_wr_i    (mctl_wr_v[m]),
      .ctl_wdata_i (bus_wdata[STATE_W-1:0]),
      .apply_i     (apply_v[MOD_DOM]),
      .ctl_o       (ctl_flat[m*STATE_W +: STATE_W]),
      .stat_o      (stat_flat[m*STATE_W +: STATE_W]),
      .clk_on_o    (clk_on_v[m])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == ADDR_W'(OFS_PEND)) bus_rdata[N_DOM-1:0] = pend_v;
      if (bus_addr == ADDR_W'(OFS_BUSY)) bus_rdata[N_DOM-1:0] = busy_v;
      for (int d = 0; d < N_DOM; d++) begin
        if (bus_addr == ADDR_W'(OFS_DSTAT + 12'(4 * d))) bus_rdata[0] = pwr_on_v[d];
        if (bus_addr == ADDR_W'(OFS_DCTL + 12'(4 * d))) begin
          bus_rdata[0]      = req_v[d];
          bus_rdata[PG_BIT] = pg_v[d];
        end
      end
      for (int m = 0; m < N_MOD; m++) begin
        if (bus_addr == ADDR_W'(OFS_MCTL + 12'(4 * m)))
          bus_rdata[STATE_W-1:0] = ctl_flat[m*STATE_W +: STATE_W];
        if (bus_addr == ADDR_W'(OFS_MSTAT + 12'(4 * m))) begin
          bus_rdata[STATE_W-1:0] = stat_flat[m*STATE_W +: STATE_W];
          bus_rdata[CLK_ON_BIT]  = clk_on_v[m];
        end
      end
    end
  end

endmodule

// File: rtl/pwr_domain_ctrl_chk.sv
module pwr_domain_ctrl_chk
  import pwr_ctrl_pkg::*;
#(
  parameter int unsigned N_DOM  = 2,
  parameter int unsigned N_MOD  = 8,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic                     bus_rd,
  input logic [DATA_W-1:0]        bus_rdata,
  input logic [N_DOM-1:0]         busy_v,
  input logic [N_DOM-1:0]         pend_v,
  input logic [N_DOM-1:0]         pwr_on_v,
  input logic [N_DOM-1:0]         apply_v,
  input logic [N_MOD*STATE_W-1:0] stat_flat
);

  // R4: command register never reads back set bits
  a_r4_cmd_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(OFS_CMD)) |-> (bus_rdata == '0));

  // R2: status moves only on a completing transition
  a_r2_stat_held: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_v == '0) |=> $stable(stat_flat));

  // R6: pending only on a domain that is off
  a_r6_pend_off: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_v & pwr_on_v) == '0));

  // R6: pending implies busy
  a_r6_pend_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_v & ~busy_v) == '0));

  // R5: apply comes from a busy domain
  a_r5_apply_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ((apply_v & ~busy_v) == '0));

  // R7: once powered on a domain stays on
  a_r7_on_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~pwr_on_v & $past(pwr_on_v)) == '0));

  // R10: idle read strobe gives zero
  a_r10_rd_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == '0));

endmodule

bind pwr_domain_ctrl pwr_domain_ctrl_chk #(
  .N_DOM  (N_DOM),
  .N_MOD  (N_MOD),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .busy_v    (busy_v),
  .pend_v    (pend_v),
  .pwr_on_v  (pwr_on_v),
  .apply_v   (apply_v),
  .stat_flat (stat_flat)
);

// File: tb/pwr_domain_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_domain_ctrl_tb_top;

  localparam int LAT = 4;
  localparam int NM  = 8;
  localparam int ND  = 2;

  localparam logic [11:0] A_PEND  = 12'h070;
  localparam logic [11:0] A_CMD   = 12'h120;
  localparam logic [11:0] A_BUSY  = 12'h128;
  localparam logic [11:0] A_DSTAT = 12'h200;
  localparam logic [11:0] A_DCTL  = 12'h300;
  localparam logic [11:0] A_MSTAT = 12'h800;
  localparam logic [11:0] A_MCTL  = 12'hA00;

  logic        clk;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_wr;
  logic        bus_rd;
  logic [31:0] bus_rdata;

  int errors = 0;
  int checks = 0;
  bit done   = 0;
  int cur_st [NM];

  pwr_domain_ctrl #(.N_DOM(ND), .N_MOD(NM), .XFER_LAT(LAT)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output int d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = int'(bus_rdata);
    bus_rd = 1'b0;
  endtask

  task automatic count_busy(output int n);
    int v;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      rd(A_BUSY, v);
      if (v == 0) break;
      n++;
    end
  endtask

  function automatic int stat_exp(input int s);
    return s | (((s == 1) || (s == 3)) ? (1 << 12) : 0);
  endfunction

  task automatic check_mods(input string req);
    int v;
    for (int m = 0; m < NM; m++) begin
      rd(A_MSTAT + 12'(4 * m), v);
      chk(req, v, stat_exp(cur_st[m]));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v;
    int n;
    bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int m = 0; m < NM; m++) cur_st[m] = 0;

    // R1 reset state
    check_mods("R1");
    for (int m = 0; m < NM; m++) begin
      rd(A_MCTL + 12'(4 * m), v); chk("R1", v, 0);
    end
    rd(A_BUSY, v);  chk("R1", v, 0);
    rd(A_PEND, v);  chk("R1", v, 0);
    rd(A_DSTAT, v); chk("R1", v, 1);
    rd(A_DSTAT + 12'd4, v); chk("R1", v, 0);
    rd(A_DCTL, v);  chk("R1", v, 1);
    rd(A_DCTL + 12'd4, v);  chk("R1", v, 0);

    // R10 unmapped and strobe-low reads
    rd(12'h004, v); chk("R10", v, 0);
    rd(12'h900, v); chk("R10", v, 0);
    @(negedge clk);
    bus_addr = A_DSTAT; bus_rd = 1'b0;
    #1 chk("R10", int'(bus_rdata), 0);

    // R2 control write, readback masking, status untouched
    for (int m = 0; m < NM; m++) wr(A_MCTL + 12'(4 * m), 32'hABCD_EF00 | 32'(m + 8));
    for (int m = 0; m < NM; m++) begin
      rd(A_MCTL + 12'(4 * m), v); chk("R2", v, m + 8);
    end
    check_mods("R2");

    // R9 GO on off domain 1 with no power request: direct run, stays off
    wr(A_CMD, 32'h2);
    count_busy(n);
    chk("R9", n, LAT);
    rd(A_DSTAT + 12'd4, v); chk("R9", v, 0);
    for (int m = 4; m < NM; m++) cur_st[m] = m + 8;
    check_mods("R5");

    // R4 command register reads zero
    rd(A_CMD, v); chk("R4", v, 0);

    // R5 GO on domain 0 only
    wr(A_CMD, 32'h1);
    count_busy(n);
    chk("R4", n, LAT);
    for (int m = 0; m < 4; m++) cur_st[m] = m + 8;
    check_mods("R5");

    // R8 second GO while busy is ignored
    wr(A_MCTL, 32'h3);
    wr(A_CMD, 32'h1);
    wr(A_CMD, 32'h1);
    count_busy(n);
    chk("R8", n, LAT - 1);
    cur_st[0] = 3;
    check_mods("R8");

    // R6 handshake on domain 1
    wr(A_DCTL + 12'd4, 32'h1);
    wr(A_MCTL + 12'd16, 32'h3);
    wr(A_CMD, 32'h2);
    rd(A_PEND, v); chk("R6", v, 2);
    rd(A_BUSY, v); chk("R6", v, 2);
    repeat (12) @(negedge clk);
    rd(A_BUSY, v); chk("R6", v, 2);
    rd(A_PEND, v); chk("R6", v, 2);
    check_mods("R6");

    // R7 power-good accepted
    wr(A_DCTL + 12'd4, 32'h101);
    count_busy(n);
    chk("R7", n, LAT + 1);
    rd(A_PEND, v); chk("R7", v, 0);
    rd(A_DSTAT + 12'd4, v); chk("R7", v, 1);
    rd(A_DCTL + 12'd4, v); chk("R7", v, 1);
    cur_st[4] = 3;
    check_mods("R7");

    // R3 sweep of every state code over all modules
    for (int s = 0; s < 32; s++) begin
      for (int m = 0; m < NM; m++) begin
        wr(A_MCTL + 12'(4 * m), 32'((s + m) % 32));
        cur_st[m] = (s + m) % 32;
      end
      wr(A_CMD, 32'h3);
      count_busy(n);
      chk("R3", n, LAT);
      check_mods("R3");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule